// File: doc/BRIEF.md
# Ethernet Transmit Interpacket Gap Timer

This block sits beside a MAC transmitter and decides when the next frame may begin. It sees the cycle that carries the final nibble of a frame's check sequence. From the clock after that cycle it counts idle clocks. Once the required gap has passed and a frame is waiting, it raises a one-cycle grant. The transmitter starts driving the preamble in the cycle after the grant. The gap therefore equals the number of clocks from the end-of-frame cycle to the grant cycle.

There are two gap rules, and the timer picks one at each end of frame:

- **Back-to-back.** If a request is already pending when the frame ends, the gap is a programmed count plus a fixed overhead. The overhead is 3 clocks in full duplex and 6 in half duplex.
- **Not back-to-back.** Otherwise a second rule applies, in two parts:
  - During an early window, carrier activity in half duplex pushes the start of the gap to the latest carrier cycle.
  - After that window, carrier is ignored until a programmed total has been reached.

Top module: `ipg_timer`

## Requirements
- R1: While reset is held, `tx_grant` is 0. After reset the gap counts as already met, so a request raised after reset is granted in the cycle it is first high.
- R2: In full duplex, a back-to-back frame is granted exactly `3 + gap_b2b` clocks after the end-of-frame cycle.
- R3: In half duplex, a back-to-back frame is granted exactly `6 + gap_b2b` clocks after the end-of-frame cycle.
- R4: A gap is back-to-back when `tx_req` is 1 in the end-of-frame cycle. During a back-to-back gap, carrier has no effect.
- R5: For a gap that is not back-to-back, with a request waiting, the grant comes `max(gap_part2, 1)` clocks after the end-of-frame cycle, provided no carrier restart occurs.
- R6: In half duplex, during a gap that is not back-to-back, carrier seen at count k (k counts clocks since end of frame, 1 in the first clock after it) restarts the count when `k <= gap_part1`. The grant then comes `gap_part2` clocks after that carrier cycle.
- R7: In half duplex, carrier seen at a count above `gap_part1` has no effect on when the grant comes.
- R8: In full duplex, carrier has no effect on when the grant comes.
- R9: The grant lasts one cycle and comes only while `tx_req` is 1. From the grant until the end-of-frame pulse that closes that frame, no grant is given.
- R10: If the gap expires with no request pending, a later request is granted in the cycle it is first high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Nibble clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| full_duplex | input | 1 | 1 = full duplex, 0 = half duplex |
| gap_b2b | input | GW (7) | Back-to-back gap count |
| gap_part1 | input | GW (7) | Last count at which carrier restarts a gap that is not back-to-back |
| gap_part2 | input | GW (7) | Total length of a gap that is not back-to-back |
| eof | input | 1 | High in the cycle carrying the final nibble of a frame |
| crs | input | 1 | Carrier sense |
| tx_req | input | 1 | A frame is waiting to be sent |
| tx_grant | output | 1 | One-cycle permission to start the preamble |

## Verification
Back-to-back gaps are run in both duplex modes with counts of 0, 15h, 12h and 7Fh. These show that the 3 and 6 overheads are applied and that the counter does not wrap at the largest setting.

Gaps that are not back-to-back are run with carrier at these points:

- none;
- inside the first window;
- exactly on its last count;
- just past it;
- in full duplex.

Together they separate a restart from an ignored carrier and locate the window boundary.

A late request checks the idle path. Carrier during a back-to-back gap, and a request held high through a frame, check that the mode latch and the grant hold-off do not leak.

// File: rtl/ipg_timer.sv
module ipg_timer #(
  parameter int GW = 7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          full_duplex,
  input  logic [GW-1:0] gap_b2b,
  input  logic [GW-1:0] gap_part1,
  input  logic [GW-1:0] gap_part2,
  input  logic          eof,
  input  logic          crs,
  input  logic          tx_req,
  output logic          tx_grant
);
  localparam int CW = GW + 2;
  localparam logic [CW-1:0] CNT_MAX = '1;

  typedef enum logic [1:0] {S_READY, S_TX, S_GAP} state_t;

  state_t        st;
  logic [CW-1:0] cnt;
  logic          b2b;

  wire [CW-1:0] target = b2b ? CW'(gap_b2b) + (full_duplex ? CW'(3) : CW'(6))
                             : CW'(gap_part2);
  wire done    = cnt >= target;
  wire restart = !full_duplex && !b2b && crs && (cnt <= CW'(gap_part1));

  assign tx_grant = rst_n && tx_req && (st == S_READY || (st == S_GAP && done));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st  <= S_READY;
      cnt <= '0;
      b2b <= 1'b0;
    end else begin
      case (st)
        S_READY: if (tx_grant) st <= S_TX;
        S_TX: if (eof) begin
          st  <= S_GAP;
          cnt <= CW'(1);
          b2b <= tx_req;
        end
        S_GAP: begin
          if (done)                 st  <= tx_req ? S_TX : S_READY;
          else if (restart)         cnt <= CW'(1);
          else if (cnt != CNT_MAX)  cnt <= cnt + CW'(1);
        end
        default: st <= S_READY;
      endcase
    end
  end
endmodule

module ipg_timer_chk #(
  parameter int GW = 7
) (
  input logic          clk,
  input logic          rst_n,
  input logic          full_duplex,
  input logic [GW-1:0] gap_b2b,
  input logic [GW-1:0] gap_part1,
  input logic [GW-1:0] gap_part2,
  input logic          eof,
  input logic          crs,
  input logic          tx_req,
  input logic          tx_grant
);
  logic       in_frame, fresh, b2b_c;
  logic [9:0] since;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_frame <= 1'b0;
      fresh    <= 1'b0;
      b2b_c    <= 1'b0;
      since    <= '0;
    end else begin
      if (tx_grant) begin
        in_frame <= 1'b1;
        fresh    <= 1'b0;
      end
      if (eof && in_frame) begin
        in_frame <= 1'b0;
        fresh    <= 1'b1;
        b2b_c    <= tx_req;
        since    <= 10'd1;
      end else if (since != 10'h3FF) begin
        since <= since + 10'd1;
      end
    end
  end

  assert_reset_quiet_R1: assert property (@(posedge clk) !rst_n |-> !tx_grant);

  assert_b2b_full_R2: assert property (@(posedge clk) disable iff (!rst_n)
    fresh && b2b_c && full_duplex && tx_grant |-> int'(since) == int'(gap_b2b) + 3);

  assert_b2b_half_R3: assert property (@(posedge clk) disable iff (!rst_n)
    fresh && b2b_c && !full_duplex && tx_grant |-> int'(since) == int'(gap_b2b) + 6);

  assert_nb_min_gap_R5: assert property (@(posedge clk) disable iff (!rst_n)
    fresh && !b2b_c && tx_grant |-> int'(since) >= int'(gap_part2) && since != 10'd0);

  assert_grant_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    tx_grant |=> !tx_grant);

  assert_grant_needs_req_R9: assert property (@(posedge clk) disable iff (!rst_n)
    tx_grant |-> tx_req);

  assert_no_grant_in_frame_R9: assert property (@(posedge clk) disable iff (!rst_n)
    in_frame |-> !tx_grant);
endmodule

bind ipg_timer ipg_timer_chk #(.GW(GW)) u_chk (.*);

// File: tb/ipg_timer_tb.sv
module ipg_timer_tb;
  localparam int CLK_PERIOD = 10;

  logic       clk = 0;
  logic       rst_n = 0;
  logic       full_duplex = 1;
  logic [6:0] gap_b2b = 7'h15, gap_part1 = 7'd8, gap_part2 = 7'd20;
  logic       eof = 0, crs = 0, tx_req = 0;
  logic       tx_grant;

  int total = 0, bad = 0;
  int cyc = 0, e_cyc = 0, r_cyc = 0;
  bit gflag = 0, in_frame = 0, prev_req = 0, finished = 0;
  int exp_q[$];
  bit kind_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  ipg_timer u_dut (.*);

  // monitor / scoreboard
  always @(negedge clk) begin
    cyc++;
    gflag = tx_grant;
    if (tx_req && !prev_req) r_cyc = cyc;
    prev_req = tx_req;
    if (rst_n && tx_grant) begin
      if (in_frame) begin
        bad++; total++;
        $display("FAIL R9: grant inside frame at cycle %0d (actual 1 expected 0)", cyc);
      end
      if (exp_q.size() == 0) begin
        bad++; total++;
        $display("FAIL R9: unexpected grant at cycle %0d (actual 1 expected 0)", cyc);
      end else begin
        int e, m;
        bit k;
        e = exp_q.pop_front();
        k = kind_q.pop_front();
        m = k ? cyc - r_cyc : cyc - e_cyc;
        total++;
        if (m != e) begin
          bad++;
          $display("FAIL gap: measured %0d expected %0d (from_req=%0d)", m, e, k);
        end
      end
      in_frame = 1;
    end
    if (eof && in_frame) begin
      e_cyc = cyc;
      in_frame = 0;
    end
  end

  task automatic tick();
    @(posedge clk); #2;
  endtask

  task automatic wait_grant();
    for (int i = 0; i < 1000; i++) begin
      @(negedge clk); #1;
      if (gflag) return;
      tick();
    end
  endtask

  task automatic xfer(input bit fd, input logic [6:0] gb, input bit keep,
                      input int crs_at, input int req_at, input int exp, input bit from_req,
                      input string tag);
    tick();
    tx_req = keep; full_duplex = fd; gap_b2b = gb;
    repeat (3) tick();
    @(negedge clk); #1;
    total++;
    if (tx_grant !== 1'b0) begin
      bad++;
      $display("FAIL R9: grant during frame (actual %0b expected 0)", tx_grant);
    end
    tick();
    eof = 1;
    exp_q.push_back(exp); kind_q.push_back(from_req);
    tick();
    eof = 0;
    for (int k = 1; k < 1000; k++) begin
      crs = (k == crs_at);
      if (!keep && k >= req_at) tx_req = 1;
      @(negedge clk); #1;
      if (gflag) break;
      tick();
    end
    crs = 0;
    $display("case %s done", tag);
  endtask

  initial begin
    tx_req = 1;
    repeat (3) tick();
    @(negedge clk); #1;
    total++;
    if (tx_grant !== 1'b0) begin
      bad++;
      $display("FAIL R1: grant in reset (actual %0b expected 0)", tx_grant);
    end
    tick();
    rst_n = 1; tx_req = 0;
    tick();
    exp_q.push_back(0); kind_q.push_back(1);   // R1 immediate first grant
    tx_req = 1;
    wait_grant();
    xfer(1, 7'h15, 1, 0,  0,  24,  0, "R2 full b2b 15h");
    xfer(0, 7'h12, 1, 0,  0,  24,  0, "R3 half b2b 12h");
    xfer(1, 7'h00, 1, 0,  0,  3,   0, "R2 full b2b 0");
    xfer(0, 7'h7F, 1, 0,  0,  133, 0, "R3 half b2b 7Fh");
    xfer(0, 7'h12, 1, 2,  0,  24,  0, "R4 carrier in b2b");
    xfer(0, 7'h12, 0, 0,  5,  20,  0, "R5 nb no carrier");
    xfer(0, 7'h12, 0, 4,  5,  24,  0, "R6 restart inside window");
    xfer(0, 7'h12, 0, 8,  5,  28,  0, "R6 restart at window edge");
    xfer(0, 7'h12, 0, 9,  5,  20,  0, "R7 carrier after window");
    xfer(1, 7'h12, 0, 4,  5,  20,  0, "R8 full duplex carrier");
    xfer(0, 7'h12, 0, 0,  40, 0,   1, "R10 late request");
    repeat (3) tick();
    if (!finished) begin
      finished = 1;
      if (exp_q.size() != 0) begin
        bad++; total++;
        $display("FAIL R9: %0d grants missing (actual 0 expected %0d)", exp_q.size(), exp_q.size());
      end
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!finished) begin
      finished = 1;
      bad++; total++;
      $display("FAIL watchdog: run hung (actual timeout expected completion)");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule